// File: doc/BRIEF.md
# Transmit Start Gating Controller

This block decides the cycle in which a network transmitter may begin sending the preamble of a queued frame. It compares the MAC-side transmit FIFO byte count against a threshold chosen by a 2-bit code. Code 3 waits for the frame's end marker to be present in the FIFO. An optional no-underflow mode also holds the start until bus-master DMA has fetched the whole frame. That mode only applies when external SRAM is present. In no-SRAM operation the threshold is the only condition.

The block gives one single-cycle start strobe per frame. It then stays disarmed until the transmitter reports the frame done. The block also holds the no-underflow mode bit. That bit can only be read or written while the controller is stopped or suspended. Hard reset and soft reset clear it, and stop leaves it as it is.

Top module: `tx_start_gate`

## Requirements
- R1: After hard reset (`rst_n` low), `start_pre` is 0, the mode bit is 0 and the gate is armed.
- R2: With threshold code 0, 1 or 2 the threshold is met when `fifo_bytes` is at least 36, 64 or 128 respectively (defaults `TH0`, `TH1`, `TH2`).
- R3: With code 3 and no-underflow mode not in effect, the threshold is met only while `eof_in_fifo` is 1.
- R4: With the mode bit 1 and `no_sram` 0, a start also needs `frame_fetched` = 1. With code 3 in this mode, `frame_fetched` alone is enough.
- R5: While `no_sram` is 1 the mode bit has no effect, and only the threshold decides.
- R6: A write (`cfg_wr_en`) loads `cfg_wr_data` into the mode bit only while `stop` or `suspend` is 1. `cfg_rd_data` shows the mode bit under the same condition and is 0 otherwise.
- R7: A `soft_rst` cycle clears the mode bit and re-arms the gate. `stop` alone does not change the mode bit.
- R8: `start_pre` rises one clock after the conditions hold and lasts one cycle. It then stays low until a `frame_done` cycle re-arms the gate.
- R9: No start strobe follows a cycle in which `stop` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset |
| stop | input | 1 | Controller stopped |
| suspend | input | 1 | Controller suspended |
| cfg_wr_en | input | 1 | Write strobe for the mode bit |
| cfg_wr_data | input | 1 | Value to write to the mode bit |
| cfg_rd_data | output | 1 | Mode bit read value |
| no_sram | input | 1 | Controller runs without external SRAM |
| thresh_code | input | 2 | Start-point threshold code |
| fifo_bytes | input | CNT_W | Bytes of the current frame in the MAC FIFO |
| eof_in_fifo | input | 1 | End of frame is in the MAC FIFO |
| frame_fetched | input | 1 | Whole frame fetched by DMA |
| frame_done | input | 1 | Transmitter finished the frame; re-arms the gate |
| start_pre | output | 1 | Single-cycle start-preamble strobe |

## Verification
The bench builds the block with its default parameters: a 12-bit byte count and thresholds of 36, 64 and 128. A 12-bit count reaches every threshold, including the value just below each one. Random byte counts are drawn around those boundaries and mixed with code-3 and fetched cases. This exercises the no-SRAM override and the stop/suspend write window against the bench's own model.

// File: rtl/tsg_pkg.sv
package tsg_pkg;

    typedef struct packed {
        logic nouf;
    } cfg_state_t;

    typedef struct packed {
        logic armed;
        logic start;
    } arm_state_t;

    localparam logic [1:0] CODE_FULL = 2'd3;

endpackage

// File: rtl/tsg_cfg.sv
module tsg_cfg
    import tsg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic stop,
    input  logic suspend,
    input  logic wr_en,
    input  logic wr_data,
    output logic nouf_q,
    output logic rd_data
);

    cfg_state_t st_d, st_q;
    logic       open_win;

    always_comb begin
        open_win = stop | suspend;
        st_d     = st_q;
        if (soft_rst) begin
            st_d.nouf = 1'b0;
        end else if (wr_en && open_win) begin
            st_d.nouf = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nouf_q  = st_q.nouf;
    assign rd_data = open_win & st_q.nouf;

endmodule

// File: rtl/tsg_thresh.sv
module tsg_thresh
    import tsg_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int TH0   = 36,
    parameter int TH1   = 64,
    parameter int TH2   = 128
) (
    input  logic [1:0]       code,
    input  logic [CNT_W-1:0] bytes,
    input  logic             eof,
    input  logic             nouf_eff,
    output logic             met
);

    localparam int NCODE = 3;

    logic [NCODE-1:0] ge;

    for (genvar i = 0; i < NCODE; i++) begin : g_cmp
        localparam int          LIM   = (i == 0) ? TH0 : ((i == 1) ? TH1 : TH2);
        localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIM);
        assign ge[i] = (bytes >= LIM_V);
    end

    always_comb begin
        if (code == CODE_FULL) begin
            met = nouf_eff | eof;
        end else begin
            met = ge[code];
        end
    end

endmodule

// File: rtl/tsg_arm.sv
module tsg_arm
    import tsg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic stop,
    input  logic met,
    input  logic gate_ok,
    input  logic frame_done,
    output logic start_q
);

    arm_state_t st_d, st_q;
    logic       fire;

    always_comb begin
        fire = st_q.armed & ~stop & met & gate_ok;
        st_d = st_q;
        if (soft_rst) begin
            st_d.armed = 1'b1;
            st_d.start = 1'b0;
        end else begin
            st_d.start = fire;
            if (fire) begin
                st_d.armed = 1'b0;
            end else if (frame_done) begin
                st_d.armed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{armed: 1'b1, start: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign start_q = st_q.start;

endmodule

// File: rtl/tx_start_gate.sv
module tx_start_gate
    import tsg_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int TH0   = 36,
    parameter int TH1   = 64,
    parameter int TH2   = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             stop,
    input  logic             suspend,
    input  logic             cfg_wr_en,
    input  logic             cfg_wr_data,
    output logic             cfg_rd_data,
    input  logic             no_sram,
    input  logic [1:0]       thresh_code,
    input  logic [CNT_W-1:0] fifo_bytes,
    input  logic             eof_in_fifo,
    input  logic             frame_fetched,
    input  logic             frame_done,
    output logic             start_pre
);

    logic nouf_q;
    logic nouf_eff;
    logic met;
    logic gate_ok;

    tsg_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_rst(soft_rst),
        .stop    (stop),
        .suspend (suspend),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .nouf_q  (nouf_q),
        .rd_data (cfg_rd_data)
    );

    assign nouf_eff = nouf_q & ~no_sram;
    assign gate_ok  = ~nouf_eff | frame_fetched;

    tsg_thresh #(
        .CNT_W(CNT_W),
        .TH0  (TH0),
        .TH1  (TH1),
        .TH2  (TH2)
    ) u_thr (
        .code    (thresh_code),
        .bytes   (fifo_bytes),
        .eof     (eof_in_fifo),
        .nouf_eff(nouf_eff),
        .met     (met)
    );

    tsg_arm u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .stop      (stop),
        .met       (met),
        .gate_ok   (gate_ok),
        .frame_done(frame_done),
        .start_q   (start_pre)
    );

endmodule

// File: rtl/tsg_chk.sv
module tsg_chk #(
    parameter int CNT_W = 12,
    parameter int TH0   = 36,
    parameter int TH1   = 64,
    parameter int TH2   = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             soft_rst,
    input logic             stop,
    input logic             suspend,
    input logic             wr_en,
    input logic             no_sram,
    input logic             fetched,
    input logic [1:0]       code,
    input logic [CNT_W-1:0] bytes,
    input logic             nouf,
    input logic             start_pre
);

    logic below;

    always_comb begin
        case (code)
            2'd0:    below = bytes < CNT_W'(TH0);
            2'd1:    below = bytes < CNT_W'(TH1);
            2'd2:    below = bytes < CNT_W'(TH2);
            default: below = 1'b0;
        endcase
    end

    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_pre |=> !start_pre);

    p_stop_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !start_pre);

    p_below_thresh_r2: assert property (@(posedge clk) disable iff (!rst_n)
        below |=> !start_pre);

    p_wait_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (nouf && !no_sram && !fetched) |=> !start_pre);

    p_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop && !suspend && !soft_rst) |=> $stable(nouf));

    p_soft_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !nouf);

    p_stop_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !wr_en && !soft_rst) |=> $stable(nouf));

endmodule

bind tx_start_gate tsg_chk #(
    .CNT_W(CNT_W),
    .TH0  (TH0),
    .TH1  (TH1),
    .TH2  (TH2)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .stop     (stop),
    .suspend  (suspend),
    .wr_en    (cfg_wr_en),
    .no_sram  (no_sram),
    .fetched  (frame_fetched),
    .code     (thresh_code),
    .bytes    (fifo_bytes),
    .nouf     (nouf_q),
    .start_pre(start_pre)
);

// File: tb/sim_tx_start_gate.sv
`timescale 1ns/1ps
module sim_tx_start_gate;

    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_rst = 0, stop = 0, suspend = 0, wr_en = 0, wr_data = 0;
    logic          noram = 0, eof = 0, fetched = 0, done = 0;
    logic [1:0]    code = 0;
    logic [CW-1:0] bytes = 0;
    logic          rd, start;

    int   n_chk = 0, n_err = 0;
    logic m_nouf, m_armed, exp_start;
    bit   finished = 0;

    always #10 clk = ~clk;

    tx_start_gate u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop(stop), .suspend(suspend),
        .cfg_wr_en(wr_en), .cfg_wr_data(wr_data), .cfg_rd_data(rd), .no_sram(noram),
        .thresh_code(code), .fifo_bytes(bytes), .eof_in_fifo(eof),
        .frame_fetched(fetched), .frame_done(done), .start_pre(start)
    );

    function automatic int th_of(input logic [1:0] c);
        return (c == 0) ? 36 : ((c == 1) ? 64 : 128);
    endfunction

    function automatic logic exp_fire(input logic armed, input logic nf);
        logic eff, thr;
        eff = nf & ~noram;
        thr = (code == 3) ? (eff | eof) : (int'(bytes) >= th_of(code));
        return armed & ~stop & thr & (~eff | fetched);
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic idle();
        soft_rst = 0; stop = 0; suspend = 0; wr_en = 0; wr_data = 0;
        noram = 0; eof = 0; fetched = 0; done = 0; code = 0; bytes = 0;
    endtask

    // Inputs set at a negedge; checks the read port, advances the model,
    // then checks the strobe at the following negedge.
    task automatic cyc(input string tag);
        logic f;
        #1;
        check({tag, " rd"}, rd, (stop | suspend) ? m_nouf : 1'b0);
        f = exp_fire(m_armed, m_nouf);
        if (soft_rst) begin
            m_nouf = 0; m_armed = 1; exp_start = 0;
        end else begin
            if (wr_en && (stop || suspend)) m_nouf = wr_data;
            exp_start = f;
            if (f) m_armed = 0;
            else if (done) m_armed = 1;
        end
        @(negedge clk);
        check(tag, start, exp_start);
    endtask

    task automatic set_nouf(input logic v);
        idle(); suspend = 1; wr_en = 1; wr_data = v; cyc("R6");
        idle();
    endtask

    task automatic rearm();
        idle(); done = 1; cyc("R8"); idle();
    endtask

    initial begin
        m_nouf = 0; m_armed = 1; exp_start = 0;
        repeat (3) @(negedge clk);
        check("R1", start, 1'b0);
        rst_n = 1;
        stop = 1; #1; check("R1", rd, 1'b0); stop = 0;
        @(negedge clk);

        // R2 boundaries for each code
        for (int c = 0; c < 3; c++) begin
            idle(); code = 2'(c); bytes = CW'(th_of(2'(c)) - 1); cyc("R2");
            bytes = CW'(th_of(2'(c))); cyc("R2");
            idle(); cyc("R8");
            rearm();
        end
        // R3 code 3 needs end marker
        idle(); code = 3; bytes = 12'd2000; cyc("R3");
        eof = 1; cyc("R3");
        rearm();
        // R8 no second strobe without frame_done
        idle(); bytes = 12'd100; cyc("R8"); cyc("R8"); cyc("R8");
        rearm();
        // R4 mode on waits for fetch
        set_nouf(1);
        idle(); bytes = 12'd500; cyc("R4");
        fetched = 1; cyc("R4");
        rearm();
        idle(); code = 3; fetched = 1; cyc("R4");
        rearm();
        // R5 no-SRAM ignores mode
        idle(); noram = 1; bytes = 12'd40; cyc("R5");
        rearm();
        // R9 stop blocks, R7 stop keeps mode
        idle(); stop = 1; bytes = 12'd300; cyc("R9"); cyc("R7");
        // R6 write outside window ignored
        idle(); wr_en = 1; wr_data = 0; cyc("R6");
        idle(); suspend = 1; cyc("R6");
        // R7 soft reset clears
        idle(); soft_rst = 1; cyc("R7");
        idle(); stop = 1; cyc("R7");

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            idle();
            code     = 2'($urandom_range(0, 3));
            bytes    = CW'(th_of(code) + $urandom_range(0, 6) - 3);
            if ($urandom_range(0, 9) == 0) bytes = CW'($urandom_range(0, 4095));
            eof      = ($urandom_range(0, 2) == 0);
            fetched  = ($urandom_range(0, 1) == 0);
            noram    = ($urandom_range(0, 3) == 0);
            stop     = ($urandom_range(0, 7) == 0);
            suspend  = ($urandom_range(0, 5) == 0);
            wr_en    = ($urandom_range(0, 4) == 0);
            wr_data  = 1'($urandom_range(0, 1));
            done     = ($urandom_range(0, 3) == 0);
            soft_rst = ($urandom_range(0, 60) == 0);
            cyc("R8");
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #(200000 * 20);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule